// File: doc/BRIEF.md
# Shared-Pin GPIO Port Controller

This block is the control logic for one eight-pin general-purpose I/O port whose pins are shared with on-chip peripherals such as a key-scan interrupt unit. Software sees three registers on a small write/read bus: an output latch, a per-pin direction mask and a per-pin pull-enable mask. Each pin's pad receives an output value, an output-buffer enable, a pull-up enable and a pull-down enable from the block. Pad inputs come back through a two-flop synchronizer before they can be read.

A peripheral can claim any pin with a per-pin ownership bit. While it owns the pin, it drives the output buffer's enable and data. The direction bit still chooses the source that a read of the data register returns. Pull devices act only while the pin's output buffer is off. On the upper group of pins, a peripheral that owns the pin and is set for rising-edge or high-level sensing turns the pull-enable bit into a pull-down request.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset the direction, pull and data registers are all zero. With no peripheral ownership every pad output enable, pull-up enable and pull-down enable is 0.
- R2: Register select `bus_addr` works as follows: 0 is the data latch, 1 is the direction mask (1 = output), 2 is the pull-enable mask and 3 is unused. Writes to 1 and 2 read back unchanged, and reading 3 returns zero.
- R3: On a pin that no peripheral owns, the output enable equals the direction bit and the pad output equals the data latch bit.
- R4: Reading register 0 returns, per pin, the latch bit when the direction bit is 1 and the synchronized pad input when it is 0. A pad change driven between two clock edges is not visible after the next edge and is visible after the second.
- R5: A write to register 0 updates the latch even while the pin is an input or is owned by a peripheral. The value reaches the pad once the pin becomes a GPIO output.
- R6: On an owned pin, the output enable equals `per_oe` and the pad output equals `per_out`, whatever the direction and latch bits hold.
- R7: On an owned pin, the direction bit still selects the read source of register 0 as in R4.
- R8: A pull device is requested only when the pin's pull bit is 1 and its output enable is 0. Both pulls are forced off on any driving pin, whether a GPIO or a peripheral drives it.
- R9: On pins 4 to 7, ownership with `per_rise`=1 turns a pull request into a pull-down with no pull-up. Pins 0 to 3 never request a pull-down, and `per_rise` on an unowned pin has no effect.
- R10: Pull-up and pull-down are never both requested on the same pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| pad_in | input | 8 | Raw pad input levels |
| per_own | input | 8 | Per-pin peripheral ownership |
| per_oe | input | 8 | Peripheral output-buffer enable |
| per_out | input | 8 | Peripheral output data |
| per_rise | input | 8 | Peripheral sensing polarity, 1 = rising edge or high level |
| pad_out | output | 8 | Pad output data |
| pad_oe | output | 8 | Pad output-buffer enable |
| pad_pu | output | 8 | Pad pull-up enable |
| pad_pd | output | 8 | Pad pull-down enable |

## Verification
The pull decision and the output-buffer handover can change in the same cycle. A pin can be both owned by a peripheral and marked for pull. On that pin, flipping `per_oe` or `per_rise` must at once switch the pull off, switch it to a pull-down, or leave a pull-up in place. The bench sets mixed ownership, direction and polarity across the upper and lower nibbles together, and then compares all four pad vectors against masks worked out per pin. Ownership also overlaps with the read path: the bench reads the data register on owned pins with mixed direction bits to confirm that each nibble comes from the correct source.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_PULL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic drive;
        logic level;
        logic up;
        logic down;
    } pin_ctl_t;

    // Resolve one pin's buffer and pull requests.
    function automatic pin_ctl_t resolve_pin(
        input logic owned,
        input logic p_oe,
        input logic p_out,
        input logic dir,
        input logic latch,
        input logic pull,
        input logic swap_ok
    );
        pin_ctl_t r;
        logic want_pull;
        logic invert;
        r.drive   = owned ? p_oe : dir;
        r.level   = owned ? p_out : latch;
        want_pull = pull & ~r.drive;
        invert    = swap_ok & owned;
        r.up      = want_pull & ~invert;
        r.down    = want_pull & invert;
        return r;
    endfunction

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] data_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] pull_q
);
    import gpio_pkg::*;

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
            pull_q <= '0;
        end else if (wr) begin
            case (sel)
                SEL_DATA: data_q <= wdata;
                SEL_DIR:  dir_q  <= wdata;
                SEL_PULL: pull_q <= wdata;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int W     = 8,
    parameter int KB_LO = 4
) (
    input  logic [W-1:0] own,
    input  logic [W-1:0] p_oe,
    input  logic [W-1:0] p_out,
    input  logic [W-1:0] p_rise,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] latch,
    input  logic [W-1:0] pull,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu,
    output logic [W-1:0] pad_pd
);
    import gpio_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic     swap_ok;
        pin_ctl_t ctl;
        if (i >= KB_LO) begin : g_swap
            assign swap_ok = p_rise[i];
        end else begin : g_fixed
            assign swap_ok = 1'b0;
        end
        assign ctl = resolve_pin(own[i], p_oe[i], p_out[i], dir[i],
                                 latch[i], pull[i], swap_ok);
        assign pad_oe[i]  = ctl.drive;
        assign pad_out[i] = ctl.level;
        assign pad_pu[i]  = ctl.up;
        assign pad_pd[i]  = ctl.down;
    end

    logic unused_rise;
    assign unused_rise = ^p_rise[(KB_LO > 0 ? KB_LO : 1)-1:0];
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl #(
    parameter int W     = 8,
    parameter int KB_LO = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bus_wr,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pad_in,
    input  logic [W-1:0] per_own,
    input  logic [W-1:0] per_oe,
    input  logic [W-1:0] per_out,
    input  logic [W-1:0] per_rise,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu,
    output logic [W-1:0] pad_pd
);
    import gpio_pkg::*;

    localparam int SYNC_STAGES = 2;

    logic [W-1:0] data_q, dir_q, pull_q, sync_q;

    gpio_regfile #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .data_q(data_q), .dir_q(dir_q), .pull_q(pull_q)
    );

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(sync_q)
    );

    gpio_pin_mux #(.W(W), .KB_LO(KB_LO)) u_mux (
        .own(per_own), .p_oe(per_oe), .p_out(per_out), .p_rise(per_rise),
        .dir(dir_q), .latch(data_q), .pull(pull_q),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    always_comb begin
        case (reg_sel_e'(bus_addr))
            SEL_DATA: bus_rdata = (dir_q & data_q) | (~dir_q & sync_q);
            SEL_DIR:  bus_rdata = dir_q;
            SEL_PULL: bus_rdata = pull_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_ctl_chk.sv
module gpio_port_ctl_chk #(
    parameter int W     = 8,
    parameter int KB_LO = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         bus_wr,
    input logic [1:0]   bus_addr,
    input logic [W-1:0] bus_wdata,
    input logic [W-1:0] pad_in,
    input logic [W-1:0] per_own,
    input logic [W-1:0] per_oe,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] pad_pu,
    input logic [W-1:0] pad_pd,
    input logic [W-1:0] data_q,
    input logic [W-1:0] sync_q
);
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    a_r10_pull_exclusive: assert property (@(posedge clk) disable iff (rst)
        (pad_pu & pad_pd) == '0);

    a_r8_no_pull_when_driving: assert property (@(posedge clk) disable iff (rst)
        ((pad_pu | pad_pd) & pad_oe) == '0);

    a_r6_owner_drives_buffer: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe ^ per_oe) & per_own) == '0);

    a_r9_low_pins_no_pulldown: assert property (@(posedge clk) disable iff (rst)
        pad_pd[KB_LO-1:0] == '0);

    a_r5_latch_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0) |=> data_q == $past(bus_wdata));

    a_r4_two_stage_sync: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> sync_q == $past(pad_in, 2));

    a_r1_reset_clears_latch: assert property (@(posedge clk)
        rst |=> data_q == '0);
endmodule

bind gpio_port_ctl gpio_port_ctl_chk #(.W(W), .KB_LO(KB_LO)) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pad_in(pad_in), .per_own(per_own), .per_oe(per_oe),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .data_q(data_q), .sync_q(sync_q)
);

// File: tb/tb_gpio_port_ctl.sv
module tb_gpio_port_ctl;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 0;
    logic       rst = 1;
    logic       bus_wr = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 0, per_own = 0, per_oe = 0, per_out = 0, per_rise = 0;
    logic [7:0] pad_out, pad_oe, pad_pu, pad_pd;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    gpio_port_ctl dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .per_own(per_own), .per_oe(per_oe), .per_out(per_out), .per_rise(per_rise),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk); rst = 0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        per_own = 0; per_oe = 0; per_rise = 0; pad_in = 0;
        do_reset();
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pad_pu", pad_pu, 8'h00);
        chk("R1 pad_pd", pad_pd, 8'h00);
        rd(2'd1, v); chk("R1 dir", v, 8'h00);
        rd(2'd2, v); chk("R1 pull", v, 8'h00);
        rd(2'd0, v); chk("R1 data", v, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(2'd1, 8'hA5); rd(2'd1, v); chk("R2 dir readback", v, 8'hA5);
        wr(2'd2, 8'h3C); rd(2'd2, v); chk("R2 pull readback", v, 8'h3C);
        wr(2'd3, 8'hFF); rd(2'd3, v); chk("R2 unused reads zero", v, 8'h00);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    endtask

    task automatic t_gpio_out();
        logic [7:0] v;
        wr(2'd0, 8'h96); wr(2'd1, 8'hFF);
        chk("R3 pad_oe", pad_oe, 8'hFF);
        chk("R3 pad_out", pad_out, 8'h96);
        rd(2'd0, v); chk("R4 read latch", v, 8'h96);
        wr(2'd2, 8'hFF);
        chk("R8 no pullup on outputs", pad_pu, 8'h00);
        wr(2'd2, 8'h00); wr(2'd1, 8'h00);
    endtask

    task automatic t_sync();
        logic [7:0] v;
        @(negedge clk); pad_in = 8'h5A;
        @(negedge clk); rd(2'd0, v); chk("R4 not after one edge", v, 8'h00);
        @(negedge clk); rd(2'd0, v); chk("R4 after two edges", v, 8'h5A);
    endtask

    task automatic t_latch();
        logic [7:0] v;
        wr(2'd0, 8'hC3);
        chk("R5 input stays off", pad_oe, 8'h00);
        rd(2'd0, v); chk("R5 input reads pad", v, 8'h5A);
        per_own = 8'hFF; per_oe = 8'h00;
        wr(2'd0, 8'h3C);
        per_own = 8'h00;
        wr(2'd1, 8'hFF);
        chk("R5 latched value appears", pad_out, 8'h3C);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_owned();
        logic [7:0] v;
        wr(2'd0, 8'h0F); wr(2'd1, 8'h0F);
        per_own = 8'hF0; per_oe = 8'h30; per_out = 8'hA0;
        #1;
        chk("R6 pad_oe mixed", pad_oe, 8'h3F);
        chk("R6 pad_out mixed", pad_out, 8'hAF);
        rd(2'd0, v); chk("R7 owned read by dir", v, 8'h5F);
        per_oe = 8'h00; per_out = 8'h00; #1;
        chk("R6 owner overrides dir", pad_oe & 8'hF0, 8'h00);
    endtask

    task automatic t_pull();
        wr(2'd2, 8'hFF);
        per_own = 8'hF0; per_oe = 8'h30; per_rise = 8'h00; #1;
        chk("R8 pullup on owned inputs", pad_pu, 8'hC0);
        chk("R8 no pulldown", pad_pd, 8'h00);
        per_rise = 8'hFF; #1;
        chk("R9 swap to pulldown", pad_pd, 8'hC0);
        chk("R9 pullup gone", pad_pu, 8'h00);
        wr(2'd1, 8'h00);
        per_own = 8'h00; #1;
        chk("R9 unowned rise ignored pu", pad_pu, 8'hFF);
        chk("R9 unowned rise ignored pd", pad_pd, 8'h00);
        per_own = 8'hFF; per_oe = 8'h00; #1;
        chk("R9 only upper pins pulldown", pad_pd, 8'hF0);
        chk("R9 lower pins keep pullup", pad_pu, 8'h0F);
        chk("R10 exclusive", pad_pu & pad_pd, 8'h00);
        per_own = 0; per_oe = 0; per_rise = 0;
    endtask

    task automatic t_reset_again();
        logic [7:0] v;
        wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
        do_reset();
        rd(2'd1, v); chk("R1 dir cleared", v, 8'h00);
        rd(2'd2, v); chk("R1 pull cleared", v, 8'h00);
        chk("R1 pad_oe cleared", pad_oe, 8'h00);
    endtask

    initial begin
        t_reset();
        t_regs();
        t_gpio_out();
        t_sync();
        t_latch();
        t_owned();
        t_pull();
        t_reset_again();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule